// File: doc/BRIEF.md
# General-Purpose I/O Port with Pin Interrupts

This block is a 32-pin general-purpose I/O port behind a single-cycle register bus. Software sets a drive value and a direction per pin, reads back the synchronized pad levels, and chooses per pin one of four interrupt sensitivities. A pin that meets its condition sets a sticky status bit. That bit raises an interrupt output only where software has unmasked the pin.

Reads are combinational from the address in the same cycle. A write is taken at the rising clock edge when the write enable is high. The interrupt outputs are split: one covers pins 0 to 15, one covers pins 16 to 31, and a third is the OR of the two. Pad electrical behaviour and pin multiplexing sit outside the block.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads zero, `pad_oe` is zero and all three interrupt outputs are low.
- R2: Register byte offsets: 0x00 drive value, 0x04 direction, 0x08 pad level (read only), 0x0C sensitivity for pins 0-15, 0x10 sensitivity for pins 16-31, 0x14 interrupt enable, 0x18 status. The writable registers read back the last value written.
- R3: `pad_oe` equals the direction register, where 1 means output. `pad_out` equals the drive value register.
- R4: `pad_in` passes through two flops. Offset 0x08 returns the synchronized level of every pin whatever its direction, two clock edges after a pad change. Writes to 0x08 are ignored.
- R5: Pin p takes its 2-bit sensitivity from bits [2*(p mod 16)+1 : 2*(p mod 16)] of the low register (p < 16) or the high register (p >= 16).
- R6: Code 0 is low level and code 1 is high level. In a level mode the status bit is set on every cycle the level holds, so a clear has no effect while the pin stays at the active level.
- R7: Code 2 is rising edge and code 3 is falling edge, judged on the synchronized level against its value one cycle earlier. The opposite edge sets nothing.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it as it was. Writing all ones clears every bit whose condition is not active.
- R9: When a hardware set and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R10: A pin drives an interrupt only when its status and enable bits are both 1. A disabled pin still records status.
- R11: `irq_lo` is the OR of enabled status over pins 0-15, `irq_hi` is the same over pins 16-31, and `irq_any` is their OR.
- R12: Accesses at an unaligned address or at an offset of 0x1C or above read as zero, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW (6) | Byte address |
| wr_en | input | 1 | Write strobe, taken at the clock edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data |
| pad_in | input | 32 | Pad levels, asynchronous |
| pad_out | output | 32 | Drive values to the pads |
| pad_oe | output | 32 | Output enables, 1 = drive |
| irq_lo | output | 1 | Interrupt for pins 0-15 |
| irq_hi | output | 1 | Interrupt for pins 16-31 |
| irq_any | output | 1 | OR of both interrupts |

## Verification
A wrong sensitivity decode or a misplaced field appears on the status register three edges after a pad change: a bit that is set when it should be clear, or the reverse. A bad mask path or a bad half split shows at once on `irq_lo`, `irq_hi` or `irq_any` once a status bit is set. A wrong clear priority shows in the cycle after a write that coincides with an edge: the status read returns zero where the set should have won. Broken synchronizer depth shifts the 0x08 readback by a cycle.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  output logic [31:0]   rd_data,
  input  logic [31:0]   pad_in,
  output logic [31:0]   pad_out,
  output logic [31:0]   pad_oe,
  output logic          irq_lo,
  output logic          irq_hi,
  output logic          irq_any
);
  localparam int IW = AW - 2;
  localparam logic [IW-1:0] IX_DOUT = IW'(0);
  localparam logic [IW-1:0] IX_DIR  = IW'(1);
  localparam logic [IW-1:0] IX_PAD  = IW'(2);
  localparam logic [IW-1:0] IX_CFGL = IW'(3);
  localparam logic [IW-1:0] IX_CFGH = IW'(4);
  localparam logic [IW-1:0] IX_MASK = IW'(5);
  localparam logic [IW-1:0] IX_STAT = IW'(6);

  logic [31:0] dout_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, stat_q;
  logic [31:0] sync1_q, sync2_q, prev_q;
  logic [31:0] hit;
  logic [31:0] w1c;

  wire [IW-1:0] widx   = addr[AW-1:2];
  wire          aligned = (addr[1:0] == 2'b00);
  wire          wr_ok  = wr_en && aligned;

  genvar g;
  generate
    for (g = 0; g < 32; g++) begin : g_pin
      logic [1:0] mode;
      if (g < 16) begin : g_low
        assign mode = cfg_lo_q[2*g +: 2];
      end else begin : g_high
        assign mode = cfg_hi_q[2*(g-16) +: 2];
      end
      always_comb begin
        case (mode)
          2'd0:    hit[g] = ~sync2_q[g];
          2'd1:    hit[g] =  sync2_q[g];
          2'd2:    hit[g] =  sync2_q[g] & ~prev_q[g];
          default: hit[g] = ~sync2_q[g] &  prev_q[g];
        endcase
      end
    end
  endgenerate

  assign w1c = (wr_ok && widx == IX_STAT) ? wr_data : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      stat_q   <= '0;
      sync1_q  <= '0;
      sync2_q  <= '0;
      prev_q   <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      stat_q  <= (stat_q & ~w1c) | hit;
      if (wr_ok) begin
        case (widx)
          IX_DOUT: dout_q   <= wr_data;
          IX_DIR:  dir_q    <= wr_data;
          IX_CFGL: cfg_lo_q <= wr_data;
          IX_CFGH: cfg_hi_q <= wr_data;
          IX_MASK: mask_q   <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (aligned) begin
      case (widx)
        IX_DOUT: rd_data = dout_q;
        IX_DIR:  rd_data = dir_q;
        IX_PAD:  rd_data = sync2_q;
        IX_CFGL: rd_data = cfg_lo_q;
        IX_CFGH: rd_data = cfg_hi_q;
        IX_MASK: rd_data = mask_q;
        IX_STAT: rd_data = stat_q;
        default: rd_data = '0;
      endcase
    end
  end

  assign pad_out = dout_q;
  assign pad_oe  = dir_q;
  assign irq_lo  = |(stat_q[15:0]  & mask_q[15:0]);
  assign irq_hi  = |(stat_q[31:16] & mask_q[31:16]);
  assign irq_any = irq_lo | irq_hi;

  AST_OE_FROM_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && widx == IX_DIR) |=> (pad_oe == $past(wr_data))); // R3
  AST_PAD_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, 2) |-> (sync2_q == $past(pad_in, 2))); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && widx == IX_STAT) |=> ((stat_q & $past(wr_data & ~hit)) == 32'h0)); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat_q & $past(hit)) == $past(hit))); // R9
  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 32'h0) |-> !irq_any); // R10
  AST_UNDEF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (!aligned || widx > IX_STAT)) |=>
      ($stable(dout_q) && $stable(dir_q) && $stable(mask_q) &&
       $stable(cfg_lo_q) && $stable(cfg_hi_q))); // R12
endmodule

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;
  localparam int AW = 6;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] pad_in = '0;
  wire  [31:0] rd_data, pad_out, pad_oe;
  wire irq_lo, irq_hi, irq_any;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  gpio_irq_port #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_any(irq_any)
  );

  always #2.5 clk = ~clk;

  // {address, write data, expected readback}
  localparam logic [69:0] TBL [0:7] = '{
    {6'h00, 32'hA5A5_5A5A, 32'hA5A5_5A5A},
    {6'h04, 32'hFFFF_0000, 32'hFFFF_0000},
    {6'h0C, 32'h1234_5678, 32'h1234_5678},
    {6'h10, 32'h9ABC_DEF0, 32'h9ABC_DEF0},
    {6'h14, 32'h0000_0000, 32'h0000_0000},
    {6'h08, 32'hFFFF_FFFF, 32'h0000_0000},
    {6'h1C, 32'hFFFF_FFFF, 32'h0000_0000},
    {6'h06, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    #1 v = rd_data;
  endtask

  task automatic setpad(input logic [31:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state, sampled while reset is held
    for (int a = 0; a < 7; a++) begin
      addr = AW'(a * 4);
      #1 chk("R1 reset register", rd_data, 32'h0);
      @(negedge clk);
    end
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 irq outputs", {29'h0, irq_lo, irq_hi, irq_any}, 32'h0);
    rst_n = 1'b1;

    // R6: default code 0 is low level; pads low keep every bit set
    repeat (4) @(negedge clk);
    rd(6'h18, v); chk("R6 low level sets all", v, 32'hFFFF_FFFF);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, v); chk("R6 R9 clear during active level", v, 32'hFFFF_FFFF);
    chk("R10 masked pins no irq", {31'h0, irq_any}, 32'h0);

    // R2 R4 R12: table of writes and readbacks
    for (int i = 0; i < 8; i++) begin
      wr(TBL[i][69:64], TBL[i][63:32]);
      rd(TBL[i][69:64], v);
      chk($sformatf("R2/R4/R12 table entry %0d", i), v, TBL[i][31:0]);
    end
    rd(6'h04, v); chk("R12 direction kept", v, 32'hFFFF_0000);
    rd(6'h00, v); chk("R12 drive value kept", v, 32'hA5A5_5A5A);
    chk("R3 pad_oe follows direction", pad_oe, 32'hFFFF_0000);
    chk("R3 pad_out follows drive value", pad_out, 32'hA5A5_5A5A);

    // switch every pin to high level (code 1)
    wr(6'h0C, 32'h5555_5555);
    wr(6'h10, 32'h5555_5555);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, v); chk("R8 clear all", v, 32'h0);

    setpad(32'h0000_0008);
    rd(6'h18, v); chk("R6 high level pin 3", v, 32'h0000_0008);
    rd(6'h08, v); chk("R4 pad level readback", v, 32'h0000_0008);
    chk("R10 disabled pin records no irq", {31'h0, irq_any}, 32'h0);
    wr(6'h14, 32'h0010_0008);
    @(negedge clk);
    chk("R11 lower half irq", {29'h0, irq_lo, irq_hi, irq_any}, 32'h5);
    wr(6'h18, 32'h0);
    rd(6'h18, v); chk("R8 write zero keeps", v, 32'h0000_0008);
    wr(6'h18, 32'h0000_0008);
    rd(6'h18, v); chk("R6 level still active", v, 32'h0000_0008);
    setpad(32'h0);
    wr(6'h18, 32'h0000_0008);
    rd(6'h18, v); chk("R8 clear after level gone", v, 32'h0);
    chk("R11 irq_lo drops", {31'h0, irq_lo}, 32'h0);

    // R5 R7: pin 20 rising edge, field bits [9:8] of the high register
    wr(6'h10, 32'h5555_5655);
    setpad(32'h0010_0000);
    rd(6'h18, v); chk("R5 R7 rising edge pin 20", v, 32'h0010_0000);
    chk("R11 upper half irq", {29'h0, irq_lo, irq_hi, irq_any}, 32'h3);
    wr(6'h18, 32'h0010_0000);
    rd(6'h18, v); chk("R7 edge not re-set while high", v, 32'h0);
    setpad(32'h0);
    rd(6'h18, v); chk("R7 falling ignored in rising mode", v, 32'h0);

    // R5 R7: pin 0 falling edge, field bits [1:0] of the low register
    wr(6'h0C, 32'h5555_5557);
    setpad(32'h0000_0001);
    rd(6'h18, v); chk("R7 rising ignored in falling mode", v, 32'h0);
    setpad(32'h0);
    rd(6'h18, v); chk("R5 R7 falling edge pin 0", v, 32'h0000_0001);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, v); chk("R8 clear edge bit", v, 32'h0);

    // R9: edge set coincides with a clear of all bits
    @(negedge clk);
    pad_in = 32'h0010_0000;
    @(negedge clk);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, v); chk("R9 set beats clear", v, 32'h0010_0000);
    chk("R9 irq_hi after race", {31'h0, irq_hi}, 32'h1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule